// File: doc/BRIEF.md
# Missing-Pulse Clock/Trigger Line Decoder

This block takes a single line that carries both a clock and a trigger, and turns it back into a separate trigger strobe. A local continuous clock, running at the line rate, stands in for a regenerated clock. On that clock the line is expected to show a pulse every cycle. The sender marks a trigger by leaving out the pulse in one cycle. The decoder samples the line once per local cycle through a two-stage synchronizer. Every cycle in which a pulse was expected but the sample is low becomes a one-cycle trigger. In effect, the trigger is the difference between the continuous clock and the line.

The decoded trigger then goes through a coarse delay of 0 to 15 whole clock cycles. The delay value is loaded through a simple serial configuration input. After reset, triggers are held off until the line has shown four normal pulses in a row, so start-up glitches cannot produce false triggers. A small encoder module, used by the testbench, builds the combined line from a trigger request. In this digital model each clock cycle is represented by one line level: high means a pulse is present, low means the pulse was left out.

Top module: `clkTrigDecoder`

## Requirements
- R1: A low line sample captured at clock edge n (line is low while the arming condition is met) makes trigOut high for exactly the one cycle that follows edge n+2+D, where D is the current coarse delay.
- R2: Each missing pulse is decoded as its own trigger. k consecutive low samples give k consecutive high cycles on trigOut.
- R3: After reset, no trigger is produced until four consecutive high samples have been seen. A low sample before that restarts the count. Once armed, the decoder stays armed until the next reset.
- R4: The coarse delay D takes any value from 0 to 15 and shifts the trigger by exactly D cycles relative to D = 0.
- R5: While cfgLoad is high, each clock edge shifts cfgData into a 4-bit shadow register, first bit ending up as the MSB. On the first edge where cfgLoad is low after having been high, the last four bits shifted become D, so a frame longer than four bits keeps only its final four bits.
- R6: D keeps its value while cfgLoad stays low, whatever cfgData does. Reset sets D to 0.
- R7: During and right after reset, trigOut is low, and the encoder's line output is high.
- R8: The encoder output is registered. In the cycle after an edge where trigReq was high it is low; otherwise it is high.
- R9: A line that keeps pulsing (high on every sample) never produces a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local continuous clock, one cycle per line pulse |
| rst_n | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Combined clock/trigger line; high = pulse present, low = pulse omitted |
| cfgLoad | input | 1 | Serial configuration frame enable |
| cfgData | input | 1 | Serial configuration data bit, MSB first |
| trigOut | output | 1 | Decoded trigger after coarse delay, one cycle per missing pulse |

## Verification
The bench first tries to fool the arming logic. It sends runs of up to three normal pulses broken by missing ones right after reset. A decoder that armed too early, or that did not restart its count, would emit false triggers there. It then sends back-to-back missing pulses: a design that merged them or detected only edges would report one trigger where three are expected. The coarse delay is checked at 0, 1, 7 and 15 cycles, where an off-by-one tap would put the trigger one cycle early or late. Finally, a six-bit frame and a toggling data bit with the frame idle show whether the delay register keeps only the last four bits and ignores data outside a frame.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  localparam int MAX_COARSE = 15;
  localparam int TAP_W = $clog2(MAX_COARSE + 1);

  typedef struct packed {
    logic             armed;
    logic [TAP_W-1:0] tapSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ctd_encoder.sv
module ctd_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic trigReq,
  output logic lineOut
);
  always_ff @(posedge clk) begin
    if (!rst_n) lineOut <= 1'b1;
    else        lineOut <= ~trigReq;
  end
endmodule

// File: rtl/ctd_control.sv
module ctd_control
  import ctd_pkg::*;
#(
  parameter int ARM_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        syncLine,
  input  logic        cfgLoad,
  input  logic        cfgData,
  output ctrlStrobe_t strobes
);
  localparam int CNT_W = $clog2(ARM_COUNT + 1);
  localparam logic [CNT_W-1:0] ARM_LIMIT = CNT_W'(ARM_COUNT);

  logic [CNT_W-1:0] armCnt;
  logic             armedNow;
  logic [TAP_W-1:0] shadowReg;
  logic [TAP_W-1:0] tapReg;
  logic             loadPrev;

  assign armedNow = (armCnt == ARM_LIMIT);

  // Arming: count consecutive normal pulses, restart on a missing one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armCnt <= '0;
    end else if (!armedNow) begin
      if (syncLine) armCnt <= armCnt + 1'b1;
      else          armCnt <= '0;
    end
  end

  // Serial configuration: shift while enabled, commit on frame end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowReg <= '0;
      tapReg    <= '0;
      loadPrev  <= 1'b0;
    end else begin
      loadPrev <= cfgLoad;
      if (cfgLoad) shadowReg <= {shadowReg[TAP_W-2:0], cfgData};
      if (loadPrev && !cfgLoad) tapReg <= shadowReg;
    end
  end

  always_comb begin
    strobes.armed  = armedNow;
    strobes.tapSel = tapReg;
  end
endmodule

// File: rtl/ctd_datapath.sv
module ctd_datapath
  import ctd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lineIn,
  input  ctrlStrobe_t strobes,
  output logic        syncLine,
  output logic        trigDet,
  output logic        trigOut
);
  logic [SYNC_STAGES-1:0] syncPipe;
  logic [MAX_COARSE-1:0]  delayLine;
  logic                   tapOut;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncPipe[gi] <= 1'b0;
          else        syncPipe[gi] <= lineIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) syncPipe[gi] <= 1'b0;
          else        syncPipe[gi] <= syncPipe[gi-1];
        end
      end
    end
  endgenerate

  assign syncLine = syncPipe[SYNC_STAGES-1];

  // Missing pulse: expected a pulse (armed) but sampled low
  always_ff @(posedge clk) begin
    if (!rst_n) trigDet <= 1'b0;
    else        trigDet <= strobes.armed & ~syncLine;
  end

  generate
    for (gi = 0; gi < MAX_COARSE; gi++) begin : g_delay
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) delayLine[gi] <= 1'b0;
          else        delayLine[gi] <= trigDet;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) delayLine[gi] <= 1'b0;
          else        delayLine[gi] <= delayLine[gi-1];
        end
      end
    end
  endgenerate

  always_comb begin
    tapOut = trigDet;
    for (int k = 0; k < MAX_COARSE; k++) begin
      if (strobes.tapSel == TAP_W'(k + 1)) tapOut = delayLine[k];
    end
  end

  assign trigOut = tapOut;
endmodule

// File: rtl/clkTrigDecoder.sv
module clkTrigDecoder
  import ctd_pkg::*;
#(
  parameter int ARM_COUNT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  input  logic cfgLoad,
  input  logic cfgData,
  output logic trigOut
);
  ctrlStrobe_t      ctrlBus;
  logic             syncLine;
  logic             trigDet;
  logic             armedW;
  logic [TAP_W-1:0] tapSelW;

  assign armedW  = ctrlBus.armed;
  assign tapSelW = ctrlBus.tapSel;

  ctd_control #(.ARM_COUNT(ARM_COUNT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .syncLine (syncLine),
    .cfgLoad  (cfgLoad),
    .cfgData  (cfgData),
    .strobes  (ctrlBus)
  );

  ctd_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .lineIn   (lineIn),
    .strobes  (ctrlBus),
    .syncLine (syncLine),
    .trigDet  (trigDet),
    .trigOut  (trigOut)
  );
endmodule

// File: rtl/clkTrigDecoder_checker.sv
module clkTrigDecoder_checker
  import ctd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfgLoad,
  input logic             syncLine,
  input logic             armedW,
  input logic [TAP_W-1:0] tapSelW,
  input logic             trigDet,
  input logic             trigOut
);
  // R1/R2: a detected trigger always comes from a low sample while armed
  assert_det_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trigDet |-> ($past(armedW) && !$past(syncLine)));

  // R3: no detection while disarmed
  assert_no_early_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armedW |=> !trigDet);

  // R3: arming is sticky
  assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armedW |=> armedW);

  // R4: zero delay passes detection straight through
  assert_zero_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tapSelW == '0) |-> (trigOut == trigDet));

  // R4: one-cycle delay lags detection by exactly one cycle
  assert_one_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tapSelW == TAP_W'(1) && $past(tapSelW) == TAP_W'(1)) |-> (trigOut == $past(trigDet)));

  // R6: the delay setting only moves at the end of a frame
  assert_tap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgLoad && !$past(cfgLoad)) |=> $stable(tapSelW));

  // R7: output quiet in reset
  always @(negedge clk) begin
    if (!rst_n) assert_reset_quiet_R7: assert (!trigOut);
  end
endmodule

bind clkTrigDecoder clkTrigDecoder_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgLoad  (cfgLoad),
  .syncLine (syncLine),
  .armedW   (armedW),
  .tapSelW  (tapSelW),
  .trigDet  (trigDet),
  .trigOut  (trigOut)
);

// File: tb/clkTrigDecoder_test.sv
module clkTrigDecoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trigReq = 1'b0;
  logic cfgLoad = 1'b0;
  logic cfgData = 1'b0;
  logic encLine;
  logic trigOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctd_encoder u_enc (.clk(clk), .rst_n(rst_n), .trigReq(trigReq), .lineOut(encLine));

  clkTrigDecoder uut (
    .clk(clk), .rst_n(rst_n), .lineIn(encLine),
    .cfgLoad(cfgLoad), .cfgData(cfgData), .trigOut(trigOut)
  );

  // Bench model built from the requirements
  localparam int HIST = 8192;
  bit expTrig [HIST];
  int edgeNum = 0;
  int benchDelay = 0;
  int hiRun = 0;
  bit armedM = 1'b0;
  bit modelLine = 1'b1;
  int winErr = 0, winTrig = 0, winEnc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      edgeNum = 0; hiRun = 0; armedM = 1'b0; modelLine = 1'b1;
      for (int i = 0; i < HIST; i++) expTrig[i] = 1'b0;
    end else begin
      edgeNum = edgeNum + 1;
      if (!modelLine) begin
        if (armedM) expTrig[(edgeNum + 2 + benchDelay) % HIST] = 1'b1;
        else hiRun = 0;
      end else if (!armedM) begin
        hiRun = hiRun + 1;
        if (hiRun >= 4) armedM = 1'b1;
      end
      modelLine = ~trigReq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && edgeNum > 0) begin
      if (trigOut !== expTrig[edgeNum % HIST]) winErr++;
      if (trigOut === 1'b1) winTrig++;
      if (encLine !== modelLine) winEnc++;
      expTrig[edgeNum % HIST] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearWin();
    winErr = 0; winTrig = 0; winEnc = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk) trigReq = 1'b1;
    end
    @(negedge clk) trigReq = 1'b0;
  endtask

  task automatic sendCfg(input logic [7:0] bits, input int n, input int newDelay);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); cfgLoad = 1'b1; cfgData = bits[i];
    end
    @(negedge clk); cfgLoad = 1'b0; cfgData = 1'b0;
    idle(3);
    benchDelay = newDelay;
  endtask

  task automatic testReset();
    rst_n = 1'b0; trigReq = 1'b0;
    idle(4);
    check(trigOut === 1'b0, "R7 trigOut in reset", trigOut, 0);
    check(encLine === 1'b1, "R7 encoder line in reset", encLine, 1);
  endtask

  task automatic testStartupGlitch();
    rst_n = 1'b0; trigReq = 1'b1;
    idle(3);
    clearWin();
    @(negedge clk) rst_n = 1'b1;
    trigReq = 1'b0; idle(1);
    request(1); idle(1);
    request(1); idle(2);
    request(1);
    idle(12);
    check(winTrig == 0 && winErr == 0, "R3 no trigger before arming", winTrig, 0);
    clearWin();
    request(1);
    idle(10);
    check(winTrig == 1 && winErr == 0, "R3 trigger once armed", winTrig, 1);
  endtask

  task automatic testSteady();
    clearWin();
    idle(60);
    check(winTrig == 0 && winErr == 0, "R9 steady pulses give no trigger", winTrig, 0);
  endtask

  task automatic testSingle();
    clearWin();
    request(1);
    idle(10);
    check(winErr == 0, "R1 single trigger timing D=0", winErr, 0);
    check(winTrig == 1, "R1 single trigger one cycle", winTrig, 1);
  endtask

  task automatic testBackToBack();
    clearWin();
    request(3);
    idle(10);
    check(winErr == 0, "R2 consecutive missing pulses timing", winErr, 0);
    check(winTrig == 3, "R2 three separate triggers", winTrig, 3);
    clearWin();
    request(1); idle(1); request(2);
    idle(10);
    check(winTrig == 3 && winErr == 0, "R2 mixed spacing", winTrig, 3);
  endtask

  task automatic testDelay(input int d);
    sendCfg(8'(d), 4, d);
    clearWin();
    request(1);
    idle(d + 10);
    check(winErr == 0, $sformatf("R4 delay %0d timing", d), winErr, 0);
    check(winTrig == 1, $sformatf("R5 delay %0d loaded, one trigger", d), winTrig, 1);
  endtask

  task automatic testLongFrame();
    // six bits 1,1,0,0,1,1 : last four 0011 -> D = 3
    sendCfg(8'b0011_0011, 6, 3);
    clearWin();
    request(1);
    idle(15);
    check(winErr == 0 && winTrig == 1, "R5 long frame keeps last four bits", winErr, 0);
  endtask

  task automatic testIdleData();
    clearWin();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) cfgData = ~cfgData;
    end
    @(negedge clk) cfgData = 1'b0;
    request(2);
    idle(15);
    check(winErr == 0 && winTrig == 2, "R6 data ignored outside frame", winErr, 0);
  endtask

  task automatic testEncoder();
    check(winEnc == 0, "R8 encoder line matches requests", winEnc, 0);
  endtask

  initial begin
    testReset();
    testStartupGlitch();
    testSteady();
    testSingle();
    testBackToBack();
    testDelay(1);
    testDelay(7);
    testDelay(15);
    testLongFrame();
    testIdleData();
    testDelay(0);
    testEncoder();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule